// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This unit turns one block-transfer request into a stream of single-word transfer descriptors. A request carries a base address, a 16-bit selection mask with one bit for each architectural register, a 2-bit addressing mode, and flags for base update, load direction and the privileged-bank request. The unit emits one descriptor for each selected register, in ascending register order. Each descriptor holds the register index and a word address, and is offered with a valid/ready handshake.

The lowest selected register always takes the lowest address, whatever the direction of the mode. When the last descriptor has been accepted, the unit raises a one-cycle completion pulse. With that pulse it reports the updated base value, whether that value should be written back, whether the program counter slot was selected, and whether the status register should be restored from its saved copy. The memory access and the register-file writes belong to the surrounding datapath.

Top module: `lsm_addr_seq`

## Requirements
- R1: After reset `busy_o`, `xfer_valid_o` and `done_o` are all 0.
- R2: An accepted request produces exactly as many descriptors as there are set bits in `reglist_i`. Bit i selects register i, and `xfer_reg_o` carries i. Descriptors come out in strictly increasing register order.
- R3: The first address depends on `mode_i` and on n, the number of set bits. Mode 0 (increment, after) starts at the base. Mode 1 (increment, before) starts at base+4. Mode 2 (decrement, after) starts at base-4n+4. Mode 3 (decrement, before) starts at base-4n.
- R4: Each following descriptor's address is 4 above the previous one. The two low bits of `base_i` are treated as zero, so every address is word aligned.
- R5: A descriptor stays on the outputs, unchanged, while `xfer_valid_o` is 1 and `xfer_ready_i` is 0. It is consumed on a clock edge where both are 1.
- R6: During the completion pulse, `wb_addr_o` equals aligned base+4n for modes 0 and 1, and aligned base-4n for modes 2 and 3. `wb_en_o` equals the `wb_req_i` given with the request.
- R7: `done_o` is 1 for exactly one cycle: the cycle after the edge that consumed the last descriptor. `xfer_valid_o` is 0 in that cycle, and the unit is idle (`busy_o`=0) in the cycle after it.
- R8: With an empty `reglist_i`, no descriptor is emitted, `done_o` rises in the cycle after the request, and `wb_addr_o` equals the aligned base.
- R9: During the completion pulse, `pc_in_list_o` equals bit 15 of the request's `reglist_i`.
- R10: `xfer_user_o` is 1 on every descriptor exactly when `priv_i` was set and the request was not a load with bit 15 selected. During the completion pulse, `status_restore_o` is 1 exactly when `priv_i` was set, `load_i` was set and bit 15 was selected.
- R11: `start_i` has no effect while `busy_o` is 1. The descriptors and the completion report of the running request are unchanged.
- R12: `xfer_last_o` is 1 on the final descriptor of a request and 0 on all others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| base_i | input | 32 | Base address |
| reglist_i | input | 16 | Register selection mask |
| mode_i | input | 2 | Addressing mode (0..3, see R3) |
| wb_req_i | input | 1 | Base update requested |
| load_i | input | 1 | Request is a load |
| priv_i | input | 1 | Privileged-bank request flag |
| busy_o | output | 1 | A request is in progress |
| xfer_valid_o | output | 1 | Descriptor valid |
| xfer_ready_i | input | 1 | Descriptor accepted by consumer |
| xfer_reg_o | output | 4 | Register index of descriptor |
| xfer_addr_o | output | 32 | Word address of descriptor |
| xfer_last_o | output | 1 | Final descriptor of the request |
| xfer_user_o | output | 1 | Descriptor uses the user register bank |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Base update enable, valid with done_o |
| wb_addr_o | output | 32 | Updated base value, valid with done_o |
| pc_in_list_o | output | 1 | Program counter slot was selected |
| status_restore_o | output | 1 | Restore status register from its saved copy |

## Verification
The assertions assume that the consumer may hold `xfer_ready_i` low for any number of cycles, and that request inputs matter only in the cycle where `start_i` is high and the unit is idle. The stimulus drives ready as always-high, alternating, and pseudo-random patterns. It covers all four modes, empty, single and full masks, and an unaligned base. It also raises a conflicting request in the middle of a running sequence, to show that the request is dropped.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  typedef enum logic [1:0] {
    AM_INC_AFTER  = 2'd0,
    AM_INC_BEFORE = 2'd1,
    AM_DEC_AFTER  = 2'd2,
    AM_DEC_BEFORE = 2'd3
  } am_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  // Clears the lowest set bit of a 16-bit mask.
  function automatic logic [15:0] drop_lowest(input logic [15:0] m);
    return m & (m - 16'd1);
  endfunction

endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/lsm_first_set.sv
module lsm_first_set #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/lsm_addr_plan.sv
module lsm_addr_plan
  import lsm_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 5,
  parameter int WORD_BYTES = 4
) (
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  am_mode_e      mode_i,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] wb_o
);
  localparam int OFF_W = $clog2(WORD_BYTES);

  logic [AW-1:0] base_al;
  logic [AW-1:0] span;
  logic [AW-1:0] step;

  assign base_al = {base_i[AW-1:OFF_W], {OFF_W{1'b0}}};
  assign span    = AW'(cnt_i) << OFF_W;
  assign step    = AW'(WORD_BYTES);

  always_comb begin
    unique case (mode_i)
      AM_INC_AFTER:  start_o = base_al;
      AM_INC_BEFORE: start_o = base_al + step;
      AM_DEC_AFTER:  start_o = base_al - span + step;
      default:       start_o = base_al - span;
    endcase
    wb_o = mode_i[1] ? (base_al - span) : (base_al + span);
  end
endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
  import lsm_pkg::*;
#(
  parameter int AW         = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [AW-1:0]           base_i,
  input  logic [NREG-1:0]         reglist_i,
  input  logic [1:0]              mode_i,
  input  logic                    wb_req_i,
  input  logic                    load_i,
  input  logic                    priv_i,
  output logic                    busy_o,
  output logic                    xfer_valid_o,
  input  logic                    xfer_ready_i,
  output logic [$clog2(NREG)-1:0] xfer_reg_o,
  output logic [AW-1:0]           xfer_addr_o,
  output logic                    xfer_last_o,
  output logic                    xfer_user_o,
  output logic                    done_o,
  output logic                    wb_en_o,
  output logic [AW-1:0]           wb_addr_o,
  output logic                    pc_in_list_o,
  output logic                    status_restore_o
);
  localparam int IW     = $clog2(NREG);
  localparam int CW     = $clog2(NREG + 1);
  localparam int PC_IDX = NREG - 1;

  seq_state_e      state_q;
  logic [NREG-1:0] mask_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   wb_q;
  logic            wb_en_q, pc_q, restore_q, user_q;

  logic [CW-1:0]   req_cnt;
  logic [AW-1:0]   plan_start, plan_wb;
  logic [IW-1:0]   cur_idx;
  logic [NREG-1:0] mask_next;

  // Named internal events
  logic seq_accept, xfer_fire, seq_last;

  lsm_popcount #(.N(NREG), .CW(CW)) u_cnt (
    .vec_i (reglist_i),
    .cnt_o (req_cnt)
  );

  lsm_addr_plan #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_plan (
    .base_i  (base_i),
    .cnt_i   (req_cnt),
    .mode_i  (am_mode_e'(mode_i)),
    .start_o (plan_start),
    .wb_o    (plan_wb)
  );

  lsm_first_set #(.N(NREG), .IW(IW)) u_first (
    .vec_i (mask_q),
    .idx_o (cur_idx)
  );

  assign mask_next  = mask_q & (mask_q - NREG'(1));
  assign seq_accept = (state_q == ST_IDLE) && start_i;
  assign xfer_fire  = (state_q == ST_RUN) && xfer_ready_i;
  assign seq_last   = (mask_next == '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      mask_q    <= '0;
      addr_q    <= '0;
      wb_q      <= '0;
      wb_en_q   <= 1'b0;
      pc_q      <= 1'b0;
      restore_q <= 1'b0;
      user_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (seq_accept) begin
            mask_q    <= reglist_i;
            addr_q    <= plan_start;
            wb_q      <= plan_wb;
            wb_en_q   <= wb_req_i;
            pc_q      <= reglist_i[PC_IDX];
            restore_q <= priv_i && load_i && reglist_i[PC_IDX];
            user_q    <= priv_i && !(load_i && reglist_i[PC_IDX]);
            state_q   <= (|reglist_i) ? ST_RUN : ST_FIN;
          end
        end
        ST_RUN: begin
          if (xfer_fire) begin
            mask_q <= mask_next;
            addr_q <= addr_q + AW'(WORD_BYTES);
            if (seq_last) state_q <= ST_FIN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o           = (state_q != ST_IDLE);
  assign xfer_valid_o     = (state_q == ST_RUN);
  assign xfer_reg_o       = cur_idx;
  assign xfer_addr_o      = addr_q;
  assign xfer_last_o      = (state_q == ST_RUN) && seq_last;
  assign xfer_user_o      = user_q;
  assign done_o           = (state_q == ST_FIN);
  assign wb_en_o          = wb_en_q;
  assign wb_addr_o        = wb_q;
  assign pc_in_list_o     = pc_q;
  assign status_restore_o = restore_q;

endmodule

// File: rtl/lsm_addr_seq_chk.sv
module lsm_addr_seq_chk #(
  parameter int AW = 32,
  parameter int IW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          xfer_valid_o,
  input logic          xfer_ready_i,
  input logic [IW-1:0] xfer_reg_o,
  input logic [AW-1:0] xfer_addr_o,
  input logic          xfer_last_o,
  input logic          done_o
);
  // R5
  xfer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && !xfer_ready_i |=> xfer_valid_o && $stable(xfer_reg_o) && $stable(xfer_addr_o));

  // R2
  step_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && xfer_ready_i && !xfer_last_o |=> xfer_valid_o && (xfer_reg_o > $past(xfer_reg_o)));

  // R4
  step_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && xfer_ready_i && !xfer_last_o |=> xfer_addr_o == $past(xfer_addr_o) + AW'(4));

  // R4
  word_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |-> xfer_addr_o[1:0] == 2'b00);

  // R7
  last_to_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && xfer_ready_i && xfer_last_o |=> done_o && !xfer_valid_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  // R12
  last_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_last_o |-> xfer_valid_o);
endmodule

bind lsm_addr_seq lsm_addr_seq_chk #(.AW(AW), .IW($clog2(NREG))) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .xfer_valid_o (xfer_valid_o),
  .xfer_ready_i (xfer_ready_i),
  .xfer_reg_o   (xfer_reg_o),
  .xfer_addr_o  (xfer_addr_o),
  .xfer_last_o  (xfer_last_o),
  .done_o       (done_o)
);

// File: tb/test_lsm_addr_seq.sv
`timescale 1ns/1ps
module test_lsm_addr_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] reglist_i = '0;
  logic [1:0]  mode_i = '0;
  logic        wb_req_i = 1'b0, load_i = 1'b0, priv_i = 1'b0;
  logic        xfer_ready_i = 1'b0;
  logic        busy_o, xfer_valid_o, xfer_last_o, xfer_user_o, done_o;
  logic [3:0]  xfer_reg_o;
  logic [31:0] xfer_addr_o, wb_addr_o;
  logic        wb_en_o, pc_in_list_o, status_restore_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] lf = 8'hA5;

  always #2.5 clk_i = ~clk_i;

  lsm_addr_seq i_lsm_addr_seq (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Behavioural reference: list of expected descriptors, then completion report.
  task automatic run_seq(input logic [31:0] base, input logic [15:0] lst, input logic [1:0] md,
                         input logic w, input logic ld, input logic s,
                         input int rdy_kind, input bit intrude);
    int          exp_reg[16];
    logic [31:0] exp_addr[16];
    int          n = 0;
    logic [31:0] ab, first, wbv;
    bit          usr, rst_flag;
    int          idx = 0;
    int          cyc = 0;
    bit          r;
    ab = base & 32'hFFFF_FFFC;
    for (int i = 0; i < 16; i++) if (lst[i]) begin exp_reg[n] = i; n++; end
    case (md)
      2'd0: first = ab;
      2'd1: first = ab + 32'd4;
      2'd2: first = ab - 32'(4 * n) + 32'd4;
      default: first = ab - 32'(4 * n);
    endcase
    for (int k = 0; k < n; k++) exp_addr[k] = first + 32'(4 * k);
    wbv = (md >= 2) ? ab - 32'(4 * n) : ab + 32'(4 * n);
    usr = s && !(ld && lst[15]);
    rst_flag = s && ld && lst[15];

    start_i = 1'b1; base_i = base; reglist_i = lst; mode_i = md;
    wb_req_i = w; load_i = ld; priv_i = s;
    @(negedge clk_i);
    start_i = 1'b0;
    while (idx < n) begin
      chk(xfer_valid_o == 1'b1, "R5 valid", 32'(xfer_valid_o), 32'd1);
      chk(busy_o == 1'b1, "R11 busy", 32'(busy_o), 32'd1);
      chk(32'(xfer_reg_o) == 32'(exp_reg[idx]), "R2 reg", 32'(xfer_reg_o), 32'(exp_reg[idx]));
      chk(xfer_addr_o == exp_addr[idx], (idx == 0) ? "R3 first addr" : "R4 next addr",
          xfer_addr_o, exp_addr[idx]);
      chk(xfer_last_o == (idx == n - 1), "R12 last", 32'(xfer_last_o), 32'(idx == n - 1));
      chk(xfer_user_o == usr, "R10 user", 32'(xfer_user_o), 32'(usr));
      chk(done_o == 1'b0, "R7 no early done", 32'(done_o), 32'd0);
      if (intrude && cyc == 0) begin
        // R11: conflicting request while busy
        start_i = 1'b1; base_i = 32'h0000_1000; reglist_i = 16'hFFFF; mode_i = 2'd3;
        wb_req_i = ~w; load_i = ~ld; priv_i = ~s;
      end else begin
        start_i = 1'b0;
      end
      case (rdy_kind)
        0: r = 1'b1;
        1: r = cyc[0];
        default: begin lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]}; r = lf[0]; end
      endcase
      xfer_ready_i = r;
      if (r) idx++;
      cyc++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    xfer_ready_i = 1'b0;
    chk(done_o == 1'b1, (n == 0) ? "R8 done empty" : "R7 done", 32'(done_o), 32'd1);
    chk(xfer_valid_o == 1'b0, "R7 valid low at done", 32'(xfer_valid_o), 32'd0);
    chk(wb_addr_o == wbv, (n == 0) ? "R8 wb addr" : "R6 wb addr", wb_addr_o, wbv);
    chk(wb_en_o == w, "R6 wb en", 32'(wb_en_o), 32'(w));
    chk(pc_in_list_o == lst[15], "R9 pc", 32'(pc_in_list_o), 32'(lst[15]));
    chk(status_restore_o == rst_flag, "R10 restore", 32'(status_restore_o), 32'(rst_flag));
    @(negedge clk_i);
    chk(done_o == 1'b0, "R7 done one cycle", 32'(done_o), 32'd0);
    chk(busy_o == 1'b0, "R7 idle", 32'(busy_o), 32'd0);
    chk(xfer_valid_o == 1'b0, "R8 no stray xfer", 32'(xfer_valid_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(busy_o == 1'b0, "R1 busy", 32'(busy_o), 32'd0);
    chk(xfer_valid_o == 1'b0, "R1 valid", 32'(xfer_valid_o), 32'd0);
    chk(done_o == 1'b0, "R1 done", 32'(done_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_seq(32'h0000_2000, 16'b0000_0000_1010_0110, 2'd0, 1'b1, 1'b1, 1'b0, 0, 1'b0);
    run_seq(32'h0000_2000, 16'b0100_0000_0000_1001, 2'd1, 1'b0, 1'b0, 1'b0, 1, 1'b0);
    run_seq(32'h0000_3000, 16'b0000_1111_0000_0001, 2'd2, 1'b1, 1'b0, 1'b0, 2, 1'b0);
    run_seq(32'h0000_3000, 16'b1000_0000_0011_0000, 2'd3, 1'b1, 1'b1, 1'b0, 2, 1'b0);
    run_seq(32'h0000_0040, 16'hFFFF,                2'd3, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    run_seq(32'hFFFF_FFF0, 16'hFFFF,                2'd0, 1'b1, 1'b1, 1'b1, 2, 1'b0);
    run_seq(32'h0000_5000, 16'h0000,                2'd1, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    run_seq(32'h0000_5000, 16'h8000,                2'd1, 1'b0, 1'b1, 1'b1, 1, 1'b0);
    run_seq(32'h0000_6003, 16'b0000_0000_0001_1000, 2'd2, 1'b1, 1'b0, 1'b1, 0, 1'b0);
    run_seq(32'h0000_7000, 16'b0010_0000_0100_0010, 2'd0, 1'b1, 1'b0, 1'b0, 1, 1'b1);
    run_seq(32'h0000_7100, 16'b0000_0000_0000_0001, 2'd3, 1'b0, 1'b1, 1'b0, 0, 1'b1);
    for (int t = 0; t < 20; t++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      run_seq({16'h0001, lf, lf ^ 8'h3C}, {lf, ~lf} ^ 16'(t * 37), 2'(t), lf[1], lf[2], lf[3], 2, t[0]);
    end
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end
endmodule